// File: doc/BRIEF.md
# GPIO Bank with Pin Event Detection

This block is a bank of 32 general-purpose pins under control of a simple word-addressed register bus. Each pin carries a 3-bit function code that says whether it is an input, a driven output, or handed to one of six alternate functions. The output latch is never written directly. One register sets the latch bits that are 1 in the written word, another clears them. This lets several agents change different pins without a read-modify-write race. A level register returns the pin states after a two-flop synchroniser.

Four per-pin enable masks select which conditions raise an event: a rising edge, a falling edge, a high level or a low level. Events land in a sticky status register, which the host clears by writing 1 to a bit. Any set status bit drives the one interrupt line of the bank. A level condition that persists sets its status bit again on every clock, so clearing it has no lasting effect until the pin changes. When an event and a clear of the same bit fall in one cycle, the event wins.

Bus writes take effect at the clock edge that samples them. A read returns its data, with `bus_rvalid`, one cycle after the request.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset, `pin_out`, `pin_oe`, `pin_func`, `irq` and every readable register are zero.
- R2: The function code of pin p is held in bits (p mod 10)*3 to (p mod 10)*3+2 of the select register at word address p/10 (addresses 0 to 3). It appears on `pin_func[3p+2:3p]` and reads back at its field position. Bits 31:30 of a select word read as 0.
- R3: `pin_oe[p]` is 1 exactly when the code of pin p is 001. Code 000 is an input, and codes 010 to 111 are alternate functions with `pin_oe[p]` low.
- R4: A write to address 16 sets every output latch bit whose data bit is 1 and leaves the rest unchanged. A read of address 16 or 17 returns the latch.
- R5: A write to address 17 clears every output latch bit whose data bit is 1 and leaves the rest unchanged.
- R6: A read of address 18 returns `pin_in` through a two-flop synchroniser. A read issued in the cycle the pins change, or in the cycle after, returns the old value, and a read issued two cycles later returns the new one.
- R7: With its bit set in the rising-edge enable (address 20), a 0-to-1 change of a synchronised pin sets its bit in the status register (address 19). Pins with the enable clear do not set a bit.
- R8: With its bit set in the falling-edge enable (address 21), a 1-to-0 change sets the status bit. Rising and falling enables may both be set on one pin.
- R9: A pin with its high-level enable (address 22) set while high, or its low-level enable (address 23) set while low, sets its status bit on every clock. A clear while the level holds leaves the bit set.
- R10: Status bits are sticky. Writing address 19 clears the bits written as 1, and bits written as 0 keep their value.
- R11: `irq` is high while any status bit is set, and it falls only after a status write has cleared the last one.
- R12: When an event and a clear of the same status bit fall in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pin_in | input | NPINS | Raw pin inputs, asynchronous |
| pin_out | output | NPINS | Output latch |
| pin_oe | output | NPINS | Output enable per pin |
| pin_func | output | 3*NPINS | Function code per pin, 3 bits each |
| irq | output | 1 | Combined event interrupt |

## Verification
A corrupted function field or output latch shows up at once on `pin_func`, `pin_oe` or `pin_out`, in the cycle after the offending write. A fault in the synchroniser or the edge history shifts or loses a status bit. That fault is visible on a status read three cycles after the pin changes, and on `irq` in the same cycle. A clear that acts on the wrong bits, or that loses against a new event when it should not, leaves a status word that differs from the one computed in the bench. This difference appears on the read that follows the clear.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int BUS_AW = 5;
    localparam int BUS_DW = 32;
    localparam int FN_W = 3;
    localparam int PINS_PER_SEL = 10;

    typedef logic [FN_W-1:0] fn_code_t;

    localparam fn_code_t FN_INPUT  = 3'b000;
    localparam fn_code_t FN_OUTPUT = 3'b001;

    // register word addresses; function select words occupy 0 .. NSEL-1
    localparam logic [BUS_AW-1:0] ADR_SET  = 5'd16;
    localparam logic [BUS_AW-1:0] ADR_CLR  = 5'd17;
    localparam logic [BUS_AW-1:0] ADR_LEV  = 5'd18;
    localparam logic [BUS_AW-1:0] ADR_STAT = 5'd19;
    localparam logic [BUS_AW-1:0] ADR_REN  = 5'd20;
    localparam logic [BUS_AW-1:0] ADR_FEN  = 5'd21;
    localparam logic [BUS_AW-1:0] ADR_HEN  = 5'd22;
    localparam logic [BUS_AW-1:0] ADR_LEN  = 5'd23;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] en_rise,
    input  logic [N-1:0] en_fall,
    input  logic [N-1:0] en_high,
    input  logic [N-1:0] en_low,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] status
);

    logic [N-1:0] prev_q;
    logic [N-1:0] hit;
    logic [N-1:0] status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= lvl;
        end
    end

    // per-pin event condition
    for (genvar p = 0; p < N; p++) begin : g_pin
        logic rise_ev;
        logic fall_ev;
        assign rise_ev = lvl[p] & ~prev_q[p];
        assign fall_ev = ~lvl[p] & prev_q[p];
        assign hit[p]  = (rise_ev & en_rise[p]) | (fall_ev & en_fall[p]) |
                         (lvl[p] & en_high[p]) | (~lvl[p] & en_low[p]);
    end

    // set has priority over a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | hit;
        end
    end

    assign status = status_q;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_evt_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_we,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [BUS_DW-1:0]   bus_wdata,
    output logic [BUS_DW-1:0]   bus_rdata,
    output logic                bus_rvalid,
    input  logic [N-1:0]        lvl,
    input  logic [N-1:0]        status,
    output logic [N-1:0]        out_latch,
    output logic [N-1:0]        en_rise,
    output logic [N-1:0]        en_fall,
    output logic [N-1:0]        en_high,
    output logic [N-1:0]        en_low,
    output logic [N-1:0]        clr_mask,
    output logic [FN_W*N-1:0]   fsel_flat
);

    localparam int NSEL = (N + PINS_PER_SEL - 1) / PINS_PER_SEL;

    logic                          wr_en;
    logic                          rd_en;
    logic [N-1:0]                  wdata_n;
    logic [NSEL-1:0][BUS_DW-1:0]   sel_word;
    logic [BUS_DW-1:0]             rdata_d;
    logic [BUS_DW-1:0]             rdata_q;
    logic                          rvalid_q;
    logic [N-1:0]                  out_q;
    logic [N-1:0]                  ren_q;
    logic [N-1:0]                  fen_q;
    logic [N-1:0]                  hen_q;
    logic [N-1:0]                  len_q;

    assign wr_en   = bus_valid & bus_we;
    assign rd_en   = bus_valid & ~bus_we;
    assign wdata_n = bus_wdata[N-1:0];

    // function select field per pin
    for (genvar p = 0; p < N; p++) begin : g_fsel
        localparam int SR = p / PINS_PER_SEL;
        localparam int SB = (p % PINS_PER_SEL) * FN_W;
        fn_code_t fld_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fld_q <= FN_INPUT;
            end else if (wr_en && bus_addr == BUS_AW'(SR)) begin
                fld_q <= bus_wdata[SB +: FN_W];
            end
        end
        assign fsel_flat[p*FN_W +: FN_W] = fld_q;
    end

    // assemble select words for readback
    for (genvar k = 0; k < NSEL; k++) begin : g_word
        for (genvar j = 0; j < PINS_PER_SEL; j++) begin : g_slot
            if (k * PINS_PER_SEL + j < N) begin : g_used
                assign sel_word[k][j*FN_W +: FN_W] =
                    fsel_flat[(k*PINS_PER_SEL + j)*FN_W +: FN_W];
            end else begin : g_pad
                assign sel_word[k][j*FN_W +: FN_W] = '0;
            end
        end
        assign sel_word[k][BUS_DW-1:PINS_PER_SEL*FN_W] = '0;
    end

    // output latch: atomic set and clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_en && bus_addr == ADR_SET) begin
            out_q <= out_q | wdata_n;
        end else if (wr_en && bus_addr == ADR_CLR) begin
            out_q <= out_q & ~wdata_n;
        end
    end

    // detect enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ren_q <= '0;
            fen_q <= '0;
            hen_q <= '0;
            len_q <= '0;
        end else if (wr_en) begin
            unique case (bus_addr)
                ADR_REN: ren_q <= wdata_n;
                ADR_FEN: fen_q <= wdata_n;
                ADR_HEN: hen_q <= wdata_n;
                ADR_LEN: len_q <= wdata_n;
                default: ;
            endcase
        end
    end

    assign clr_mask = (wr_en && bus_addr == ADR_STAT) ? wdata_n : '0;

    // read multiplexer
    always_comb begin
        rdata_d = '0;
        unique case (bus_addr)
            ADR_SET, ADR_CLR: rdata_d = BUS_DW'(out_q);
            ADR_LEV:          rdata_d = BUS_DW'(lvl);
            ADR_STAT:         rdata_d = BUS_DW'(status);
            ADR_REN:          rdata_d = BUS_DW'(ren_q);
            ADR_FEN:          rdata_d = BUS_DW'(fen_q);
            ADR_HEN:          rdata_d = BUS_DW'(hen_q);
            ADR_LEN:          rdata_d = BUS_DW'(len_q);
            default: begin
                for (int k = 0; k < NSEL; k++) begin
                    if (bus_addr == BUS_AW'(k)) begin
                        rdata_d = sel_word[k];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_en;
            if (rd_en) begin
                rdata_q <= rdata_d;
            end
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign out_latch  = out_q;
    assign en_rise    = ren_q;
    assign en_fall    = fen_q;
    assign en_high    = hen_q;
    assign en_low     = len_q;

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
    import gpio_evt_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_we,
    input  logic [BUS_AW-1:0]       bus_addr,
    input  logic [BUS_DW-1:0]       bus_wdata,
    output logic [BUS_DW-1:0]       bus_rdata,
    output logic                    bus_rvalid,
    input  logic [NPINS-1:0]        pin_in,
    output logic [NPINS-1:0]        pin_out,
    output logic [NPINS-1:0]        pin_oe,
    output logic [FN_W*NPINS-1:0]   pin_func,
    output logic                    irq
);

    logic [NPINS-1:0]      lvl_sync;
    logic [NPINS-1:0]      evt_status;
    logic [NPINS-1:0]      en_rise;
    logic [NPINS-1:0]      en_fall;
    logic [NPINS-1:0]      en_high;
    logic [NPINS-1:0]      en_low;
    logic [NPINS-1:0]      clr_mask;
    logic [FN_W*NPINS-1:0] fsel_flat;

    gpio_sync #(
        .N      (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (lvl_sync)
    );

    gpio_regs #(
        .N (NPINS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .lvl       (lvl_sync),
        .status    (evt_status),
        .out_latch (pin_out),
        .en_rise   (en_rise),
        .en_fall   (en_fall),
        .en_high   (en_high),
        .en_low    (en_low),
        .clr_mask  (clr_mask),
        .fsel_flat (fsel_flat)
    );

    gpio_detect #(
        .N (NPINS)
    ) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl_sync),
        .en_rise (en_rise),
        .en_fall (en_fall),
        .en_high (en_high),
        .en_low  (en_low),
        .clr_mask(clr_mask),
        .status  (evt_status)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_oe
        assign pin_oe[p] = (fsel_flat[p*FN_W +: FN_W] == FN_OUTPUT);
    end

    assign pin_func = fsel_flat;
    assign irq      = |evt_status;

endmodule

// File: rtl/gpio_evt_bank_chk.sv
module gpio_evt_bank_chk
    import gpio_evt_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [N-1:0]      pin_out,
    input logic              irq,
    input logic [N-1:0]      evt_status
);

    logic wr_set;
    logic wr_clr;
    logic wr_stat;

    assign wr_set  = bus_valid && bus_we && bus_addr == ADR_SET;
    assign wr_clr  = bus_valid && bus_we && bus_addr == ADR_CLR;
    assign wr_stat = bus_valid && bus_we && bus_addr == ADR_STAT;

    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pin_out & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

    // R5
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pin_out & $past(bus_wdata[N-1:0])) == '0));

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(pin_out));

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((evt_status & $past(evt_status)) == $past(evt_status)));

    // R10
    w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((evt_status & $past(evt_status & ~bus_wdata[N-1:0])) ==
                     $past(evt_status & ~bus_wdata[N-1:0])));

    // R11
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_stat));

endmodule

bind gpio_evt_bank gpio_evt_bank_chk #(.N(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .irq       (irq),
    .evt_status(evt_status)
);

// File: tb/gpio_evt_bank_tb.sv
`timescale 1ns/1ps
module gpio_evt_bank_tb;
    import gpio_evt_pkg::*;

    localparam int N = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_we = 1'b0;
    logic [4:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            bus_rvalid;
    logic [N-1:0]    pin_in = '0;
    logic [N-1:0]    pin_out;
    logic [N-1:0]    pin_oe;
    logic [3*N-1:0]  pin_func;
    logic            irq;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    gpio_evt_bank #(.NPINS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_func(pin_func), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] exp_out;
        logic [3*N-1:0] exp_func;
        logic [N-1:0] exp_oe;
        logic [31:0] exp_word [4];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "pin_out", 128'(pin_out), 128'(0));
        chk("R1", "pin_oe", 128'(pin_oe), 128'(0));
        chk("R1", "pin_func", 128'(pin_func), 128'(0));
        chk("R1", "irq", 128'(irq), 128'(0));
        rd(ADR_STAT, rv); chk("R1", "status", 128'(rv), 128'(0));
        rd(5'd0, rv);     chk("R1", "sel0", 128'(rv), 128'(0));
        rd(ADR_REN, rv);  chk("R1", "rise_en", 128'(rv), 128'(0));

        // R4 / R5 set and clear sweeps
        exp_out = '0;
        for (int p = 0; p < N; p++) begin
            wr(ADR_SET, 32'(1) << p);
            exp_out |= 32'(1) << p;
            chk("R4", "set sweep", 128'(pin_out), 128'(exp_out));
        end
        wr(ADR_CLR, 32'h0F0F_00FF);
        exp_out &= ~32'h0F0F_00FF;
        chk("R5", "clear multi", 128'(pin_out), 128'(exp_out));
        rd(ADR_CLR, rv); chk("R4", "latch readback", 128'(rv), 128'(exp_out));
        for (int p = 0; p < N; p++) begin
            wr(ADR_CLR, 32'(1) << p);
            exp_out &= ~(32'(1) << p);
            chk("R5", "clear sweep", 128'(pin_out), 128'(exp_out));
        end
        wr(ADR_SET, 32'h8000_0011);
        wr(ADR_SET, 32'h0000_0100);
        chk("R4", "set keeps others", 128'(pin_out), 128'(32'h8000_0111));
        rd(ADR_SET, rv); chk("R4", "set readback", 128'(rv), 128'(32'h8000_0111));
        wr(ADR_CLR, 32'hFFFF_FFFF);

        // R2 / R3 field placement, code (p*3+1) mod 8 per pin
        exp_func = '0; exp_oe = '0;
        for (int k = 0; k < 4; k++) exp_word[k] = '0;
        for (int p = 0; p < N; p++) begin
            logic [2:0] c;
            c = 3'((p * 3 + 1) % 8);
            exp_func[p*3 +: 3] = c;
            exp_oe[p] = (c == 3'b001);
            exp_word[p/10][(p%10)*3 +: 3] = c;
        end
        for (int k = 0; k < 4; k++) wr(5'(k), exp_word[k] | 32'hC000_0000);
        chk("R2", "pin_func map", 128'(pin_func), 128'(exp_func));
        chk("R3", "pin_oe map", 128'(pin_oe), 128'(exp_oe));
        for (int k = 0; k < 4; k++) begin
            rd(5'(k), rv);
            chk("R2", "select readback", 128'(rv), 128'(exp_word[k]));
        end
        for (int c = 0; c < 8; c++) begin
            wr(5'd3, 32'(c) << 3);
            chk("R2", "pin31 code", 128'(pin_func[93 +: 3]), 128'(c));
            chk("R3", "pin31 oe", 128'(pin_oe[31]), 128'(c == 1));
        end
        for (int k = 0; k < 4; k++) wr(5'(k), 32'h0);
        chk("R3", "all inputs", 128'(pin_oe), 128'(0));

        // R6 synchroniser latency
        pin_in = 32'hA5A5_0F0F;
        rd(ADR_LEV, rv); chk("R6", "level same cycle", 128'(rv), 128'(0));
        rd(ADR_LEV, rv); chk("R6", "level one later", 128'(rv), 128'(0));
        rd(ADR_LEV, rv); chk("R6", "level two later", 128'(rv), 128'(32'hA5A5_0F0F));
        pin_in = '0;
        idle(4);
        rd(ADR_LEV, rv); chk("R6", "level zero", 128'(rv), 128'(0));

        // R7 rising edge per pin, falls ignored while fall disabled (R8)
        wr(ADR_REN, 32'hFFFF_FFFF);
        for (int p = 0; p < N; p++) begin
            pin_in = 32'(1) << p;
            idle(4);
            rd(ADR_STAT, rv); chk("R7", "rise status", 128'(rv), 128'(32'(1) << p));
            chk("R11", "irq on rise", 128'(irq), 128'(1));
            pin_in = '0;
            idle(4);
            rd(ADR_STAT, rv); chk("R8", "fall not enabled", 128'(rv), 128'(32'(1) << p));
            wr(ADR_STAT, 32'hFFFF_FFFF);
            rd(ADR_STAT, rv); chk("R10", "cleared", 128'(rv), 128'(0));
            chk("R11", "irq low", 128'(irq), 128'(0));
        end
        wr(ADR_REN, 32'h0000_0000);

        // R8 falling edge on low half
        wr(ADR_FEN, 32'h0000_FFFF);
        pin_in = 32'hFFFF_FFFF;
        idle(4);
        rd(ADR_STAT, rv); chk("R7", "rise disabled", 128'(rv), 128'(0));
        pin_in = '0;
        idle(4);
        rd(ADR_STAT, rv); chk("R8", "fall status", 128'(rv), 128'(32'h0000_FFFF));
        wr(ADR_STAT, 32'hFFFF_FFFF);
        wr(ADR_FEN, 32'h0000_0008);
        wr(ADR_REN, 32'h0000_0008);
        pin_in = 32'h8; idle(4);
        rd(ADR_STAT, rv); chk("R8", "both edges rise", 128'(rv), 128'(32'h8));
        wr(ADR_STAT, 32'h8);
        pin_in = 32'h0; idle(4);
        rd(ADR_STAT, rv); chk("R8", "both edges fall", 128'(rv), 128'(32'h8));
        wr(ADR_STAT, 32'h8);
        wr(ADR_FEN, 32'h0); wr(ADR_REN, 32'h0);

        // R9 level detect
        wr(ADR_HEN, 32'h20);
        pin_in = 32'h20; idle(4);
        rd(ADR_STAT, rv); chk("R9", "high level", 128'(rv), 128'(32'h20));
        wr(ADR_STAT, 32'h20);
        rd(ADR_STAT, rv); chk("R9", "high persists", 128'(rv), 128'(32'h20));
        pin_in = 32'h0; idle(4);
        wr(ADR_STAT, 32'h20);
        rd(ADR_STAT, rv); chk("R9", "high gone", 128'(rv), 128'(0));
        wr(ADR_HEN, 32'h0);
        wr(ADR_LEN, 32'h40); idle(2);
        rd(ADR_STAT, rv); chk("R9", "low level", 128'(rv), 128'(32'h40));
        chk("R11", "irq low-level", 128'(irq), 128'(1));
        wr(ADR_LEN, 32'h0);
        wr(ADR_STAT, 32'hFFFF_FFFF);
        rd(ADR_STAT, rv); chk("R9", "low disabled clear", 128'(rv), 128'(0));

        // R10 / R11 partial clears
        wr(ADR_REN, 32'h88);
        pin_in = 32'h88; idle(4);
        rd(ADR_STAT, rv); chk("R7", "two rises", 128'(rv), 128'(32'h88));
        wr(ADR_STAT, 32'h8);
        rd(ADR_STAT, rv); chk("R10", "partial clear", 128'(rv), 128'(32'h80));
        chk("R11", "irq held", 128'(irq), 128'(1));
        wr(ADR_STAT, 32'h0);
        rd(ADR_STAT, rv); chk("R10", "zero write", 128'(rv), 128'(32'h80));

        // R12 set wins over simultaneous clear on bit 7
        pin_in = 32'h0; idle(4);
        pin_in = 32'h80;
        idle(2);
        wr(ADR_STAT, 32'h80);
        rd(ADR_STAT, rv); chk("R12", "set beats clear", 128'(rv), 128'(32'h80));
        wr(ADR_STAT, 32'h80);
        rd(ADR_STAT, rv); chk("R10", "plain clear", 128'(rv), 128'(0));
        chk("R11", "irq released", 128'(irq), 128'(0));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule